// File: doc/BRIEF.md
# Priority Pin-Assignment Crossbar

This block places the digital signals of a set of on-chip peripherals onto a bank of 20 general-purpose pins. The bank is port 0 (pins 0 to 7), port 1 (pins 8 to 15) and port 2 (pins 16 to 19), and it is filled in that order. Each enabled peripheral contributes a fixed group of signals. The block walks those signals in priority order and hands each one the lowest-numbered pin that is still free. Per-port skip masks reserve pins, and a reserved pin is never handed out. A pin that receives no signal stays under the control of its port latch.

The placement is recomputed combinationally from the configuration on every cycle, and a single register stage presents it at the pads. For every pin the block reports which signal it carries, a drive value and an output enable. In the reverse direction, each peripheral input receives the pad level of the pin it was given. A sticky-free overflow flag reports that the requested signals outnumber the free pins. Until the global enable is set, no pin is driven and no peripheral is connected.

Top module: `pin_xbar`

## Requirements
- R1: While rst_n is low, every pin_oe and pin_do bit is 0, every pin_sel code is 0, every periph_in bit is 1 and xbar_ovf is 0.
- R2: When xbar_en is 0, the outputs one cycle later are identical to the reset state of R1, whatever the other inputs are.
- R3: Signal indices, in priority order, are: 0 UART TX, 1 UART RX, 2 SPI clock, 3 SPI MISO, 4 SPI MOSI, 5 SPI select, 6 SMBus data, 7 SMBus clock, 8 comparator synchronous output, 9 comparator asynchronous output, 10 system clock output, 11 to 14 PCA channels 0 to 3, 15 timer T0 input, 16 timer T1 input. uart_en requests 0-1, spi_en requests 2-5, smb_en requests 6-7, cmp_en requests 8-9, sysclk_en requests 10, tmr_en requests 15-16.
- R4: With xbar_en at 1, the requested signals, taken in ascending index order, occupy the non-skipped pins in ascending pin order, one signal per pin. pin_sel for pin p (bits 5p+4..5p) holds the signal index plus 1, or 0 when the pin carries no signal.
- R5: Pin bit n of skip_p0, skip_p1 and skip_p2 reserves pin n, n+8 and n+16 respectively. A reserved pin has pin_sel 0 and the signal that would have landed on it moves to the next non-reserved pin.
- R6: A signal whose group is not enabled takes no pin, so every lower-priority signal moves down to lower pin numbers.
- R7: Requested signals beyond the number of free pins are left unrouted, the lowest-priority ones first. xbar_ovf is 1 exactly when xbar_en is 1 and the requested signals outnumber the non-skipped pins.
- R8: A pin that carries signal s drives pin_do = periph_out[s] and pin_oe = periph_oe[s].
- R9: With xbar_en at 1, a pin that carries no signal (skipped or left over) behaves as an open-drain latch output: pin_do = 0 and pin_oe = NOT port_latch of that pin.
- R10: periph_in[s] equals pin_in of the pin that carries signal s, and 1 when signal s is not routed.
- R11: All outputs follow the inputs sampled at the previous rising clock edge; a change of input is not visible before that edge.
- R12: PCA channel k (signal 11+k) is requested when pca_cnt is greater than k; pca_cnt values 5, 6 and 7 act as 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| uart_en | input | 1 | UART group request |
| spi_en | input | 1 | SPI group request |
| smb_en | input | 1 | SMBus group request |
| cmp_en | input | 1 | Comparator output group request |
| sysclk_en | input | 1 | System clock output request |
| pca_cnt | input | 3 | Number of PCA channels to route (0 to 4) |
| tmr_en | input | 1 | Timer input pair request |
| skip_p0 | input | 8 | Port 0 reservation mask |
| skip_p1 | input | 8 | Port 1 reservation mask |
| skip_p2 | input | 4 | Port 2 reservation mask |
| port_latch | input | 20 | Port latch bit per pin |
| periph_out | input | 17 | Peripheral drive value per signal |
| periph_oe | input | 17 | Peripheral output enable per signal |
| pin_in | input | 20 | Pad input level per pin |
| pin_sel | output | 100 | Per-pin 5-bit signal code (index plus 1, 0 for none) |
| pin_do | output | 20 | Per-pin drive value |
| pin_oe | output | 20 | Per-pin output enable |
| periph_in | output | 17 | Pad level delivered to each peripheral signal |
| xbar_ovf | output | 1 | Requested signals exceed free pins |

## Verification
A wrong pin rank or signal rank shifts every later signal by one or more pins, so pin_sel codes, drive values and periph_in all disagree one cycle after the offending configuration is applied. A broken skip decode shows as a nonzero code on a reserved pin or a signal parked on the wrong port, again one cycle later. The checks compare every pin and every peripheral input against an independent sequential placement model each cycle, with sparse random skip masks and directed cases for empty ports, full reservation and oversubscription.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // signal indices in priority order
  localparam int SIG_UART_TX  = 0;
  localparam int SIG_UART_RX  = 1;
  localparam int SIG_SPI_SCK  = 2;
  localparam int SIG_SPI_NSS  = 5;
  localparam int SIG_SMB_SDA  = 6;
  localparam int SIG_SMB_SCL  = 7;
  localparam int SIG_CMP_SYN  = 8;
  localparam int SIG_CMP_ASY  = 9;
  localparam int SIG_SYSCLK   = 10;
  localparam int SIG_PCA0     = 11;
  localparam int PCA_MAX      = 4;
  localparam int SIG_T0       = SIG_PCA0 + PCA_MAX;
  localparam int SIG_T1       = SIG_T0 + 1;
  localparam int N_SIG        = SIG_T1 + 1;
  localparam int SEL_W        = $clog2(N_SIG + 1);
  localparam int PCA_CNT_W    = $clog2(PCA_MAX + 1);
endpackage

// File: rtl/xbar_req_map.sv
module xbar_req_map
  import xbar_pkg::*;
(
  input  logic                 uart_en,
  input  logic                 spi_en,
  input  logic                 smb_en,
  input  logic                 cmp_en,
  input  logic                 sysclk_en,
  input  logic [PCA_CNT_W-1:0] pca_cnt,
  input  logic                 tmr_en,
  output logic [N_SIG-1:0]     sig_req
);
  always_comb begin
    sig_req = '0;
    sig_req[SIG_UART_TX] = uart_en;
    sig_req[SIG_UART_RX] = uart_en;
    for (int i = SIG_SPI_SCK; i <= SIG_SPI_NSS; i++) begin
      sig_req[i] = spi_en;
    end
    sig_req[SIG_SMB_SDA] = smb_en;
    sig_req[SIG_SMB_SCL] = smb_en;
    sig_req[SIG_CMP_SYN] = cmp_en;
    sig_req[SIG_CMP_ASY] = cmp_en;
    sig_req[SIG_SYSCLK]  = sysclk_en;
    for (int k = 0; k < PCA_MAX; k++) begin
      sig_req[SIG_PCA0 + k] = (pca_cnt > PCA_CNT_W'(k));
    end
    sig_req[SIG_T0] = tmr_en;
    sig_req[SIG_T1] = tmr_en;
  end
endmodule

// File: rtl/xbar_rank.sv
module xbar_rank #(
  parameter int N  = 8,
  parameter int RW = $clog2(N + 1)
) (
  input  logic [N-1:0]         vec,
  output logic [N-1:0][RW-1:0] rank,
  output logic [RW-1:0]        total
);
  // rank[i] = number of set bits below position i
  logic [RW-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = acc;
      acc     = acc + RW'(vec[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux
  import xbar_pkg::*;
#(
  parameter int N_PIN = 20,
  parameter int RW    = 5
) (
  input  logic                        xbar_en,
  input  logic [N_PIN-1:0]            pin_free,
  input  logic [N_PIN-1:0][RW-1:0]    pin_rank,
  input  logic [N_SIG-1:0]            sig_req,
  input  logic [N_SIG-1:0][RW-1:0]    sig_rank,
  input  logic [N_SIG-1:0]            periph_out,
  input  logic [N_SIG-1:0]            periph_oe,
  input  logic [N_PIN-1:0]            port_latch,
  input  logic [N_PIN-1:0]            pin_in,
  output logic [N_PIN-1:0][SEL_W-1:0] sel_d,
  output logic [N_PIN-1:0]            do_d,
  output logic [N_PIN-1:0]            oe_d,
  output logic [N_SIG-1:0]            pin_to_sig_d
);
  logic [N_PIN-1:0][N_SIG-1:0] hit;

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    for (genvar s = 0; s < N_SIG; s++) begin : g_sig
      assign hit[p][s] = xbar_en & pin_free[p] & sig_req[s] &
                         (pin_rank[p] == sig_rank[s]);
    end
  end

  always_comb begin
    for (int p = 0; p < N_PIN; p++) begin
      sel_d[p] = '0;
      do_d[p]  = 1'b0;
      oe_d[p]  = xbar_en & ~port_latch[p];
      for (int s = 0; s < N_SIG; s++) begin
        if (hit[p][s]) begin
          sel_d[p] = SEL_W'(s + 1);
          do_d[p]  = periph_out[s];
          oe_d[p]  = periph_oe[s];
        end
      end
    end
  end

  always_comb begin
    pin_to_sig_d = '1;
    for (int s = 0; s < N_SIG; s++) begin
      for (int p = 0; p < N_PIN; p++) begin
        if (hit[p][s]) pin_to_sig_d[s] = pin_in[p];
      end
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import xbar_pkg::*;
#(
  parameter int P0_W = 8,
  parameter int P1_W = 8,
  parameter int P2_W = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 xbar_en,
  input  logic                                 uart_en,
  input  logic                                 spi_en,
  input  logic                                 smb_en,
  input  logic                                 cmp_en,
  input  logic                                 sysclk_en,
  input  logic [PCA_CNT_W-1:0]                 pca_cnt,
  input  logic                                 tmr_en,
  input  logic [P0_W-1:0]                      skip_p0,
  input  logic [P1_W-1:0]                      skip_p1,
  input  logic [P2_W-1:0]                      skip_p2,
  input  logic [P0_W+P1_W+P2_W-1:0]            port_latch,
  input  logic [N_SIG-1:0]                     periph_out,
  input  logic [N_SIG-1:0]                     periph_oe,
  input  logic [P0_W+P1_W+P2_W-1:0]            pin_in,
  output logic [(P0_W+P1_W+P2_W)*SEL_W-1:0]    pin_sel,
  output logic [P0_W+P1_W+P2_W-1:0]            pin_do,
  output logic [P0_W+P1_W+P2_W-1:0]            pin_oe,
  output logic [N_SIG-1:0]                     periph_in,
  output logic                                 xbar_ovf
);
  localparam int N_PIN = P0_W + P1_W + P2_W;
  localparam int N_MAX = (N_PIN > N_SIG) ? N_PIN : N_SIG;
  localparam int RW    = $clog2(N_MAX + 1);

  logic [N_PIN-1:0]            skip_all, pin_free;
  logic [N_SIG-1:0]            sig_req;
  logic [N_PIN-1:0][RW-1:0]    pin_rank;
  logic [N_SIG-1:0][RW-1:0]    sig_rank;
  logic [RW-1:0]               pin_total, sig_total;
  logic [N_PIN-1:0][SEL_W-1:0] sel_d, sel_q;
  logic [N_PIN-1:0]            do_d, do_q, oe_d, oe_q;
  logic [N_SIG-1:0]            in_d, in_q;
  logic                        ovf_d, ovf_q;

  assign skip_all = {skip_p2, skip_p1, skip_p0};
  assign pin_free = ~skip_all;

  xbar_req_map u_req (
    .uart_en   (uart_en),
    .spi_en    (spi_en),
    .smb_en    (smb_en),
    .cmp_en    (cmp_en),
    .sysclk_en (sysclk_en),
    .pca_cnt   (pca_cnt),
    .tmr_en    (tmr_en),
    .sig_req   (sig_req)
  );

  xbar_rank #(.N(N_PIN), .RW(RW)) u_pin_rank (
    .vec   (pin_free),
    .rank  (pin_rank),
    .total (pin_total)
  );

  xbar_rank #(.N(N_SIG), .RW(RW)) u_sig_rank (
    .vec   (sig_req),
    .rank  (sig_rank),
    .total (sig_total)
  );

  xbar_pin_mux #(.N_PIN(N_PIN), .RW(RW)) u_mux (
    .xbar_en      (xbar_en),
    .pin_free     (pin_free),
    .pin_rank     (pin_rank),
    .sig_req      (sig_req),
    .sig_rank     (sig_rank),
    .periph_out   (periph_out),
    .periph_oe    (periph_oe),
    .port_latch   (port_latch),
    .pin_in       (pin_in),
    .sel_d        (sel_d),
    .do_d         (do_d),
    .oe_d         (oe_d),
    .pin_to_sig_d (in_d)
  );

  assign ovf_d = xbar_en & (sig_total > pin_total);

  // output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      do_q  <= '0;
      oe_q  <= '0;
      in_q  <= '1;
      ovf_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      do_q  <= do_d;
      oe_q  <= oe_d;
      in_q  <= in_d;
      ovf_q <= ovf_d;
    end
  end

  assign pin_sel   = sel_q;
  assign pin_do    = do_q;
  assign pin_oe    = oe_q;
  assign periph_in = in_q;
  assign xbar_ovf  = ovf_q;

  // checks on the registered placement
  logic [N_PIN-1:0] used_pin;
  for (genvar p = 0; p < N_PIN; p++) begin : g_used
    assign used_pin[p] = (sel_q[p] != '0);
  end

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig_chk
    logic [N_PIN-1:0] col;
    for (genvar p = 0; p < N_PIN; p++) begin : g_col
      assign col[p] = (sel_q[p] == SEL_W'(s + 1));
    end
    AST_ONE_PIN_PER_SIG: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col)); // R4
  end

  for (genvar p = 0; p < N_PIN; p++) begin : g_skip_chk
    AST_SKIP_HOLDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      skip_all[p] |=> (pin_sel[p*SEL_W +: SEL_W] == '0)); // R5
  end

  AST_OFF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_en |=> (pin_oe == '0 && pin_sel == '0 && !xbar_ovf)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (xbar_en && (sig_total <= pin_total)) |=> !xbar_ovf); // R7

  AST_OVF_FILLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    xbar_ovf |-> ($countones(used_pin) == 32'($past(pin_total)))); // R7
endmodule

// File: tb/tb_pin_xbar.sv
module tb_pin_xbar;
  localparam int NP = 20;
  localparam int NS = 17;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic xbar_en, uart_en, spi_en, smb_en, cmp_en, sysclk_en, tmr_en;
  logic [2:0] pca_cnt;
  logic [7:0] skip_p0, skip_p1;
  logic [3:0] skip_p2;
  logic [NP-1:0] port_latch, pin_in;
  logic [NS-1:0] periph_out, periph_oe;
  logic [NP*SW-1:0] pin_sel;
  logic [NP-1:0] pin_do, pin_oe;
  logic [NS-1:0] periph_in;
  logic xbar_ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [NP*SW-1:0] e_sel;
  logic [NP-1:0]    e_do, e_oe;
  logic [NS-1:0]    e_in;
  logic             e_ovf;

  always #10 clk = ~clk;

  pin_xbar dut (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .uart_en(uart_en),
    .spi_en(spi_en), .smb_en(smb_en), .cmp_en(cmp_en), .sysclk_en(sysclk_en),
    .pca_cnt(pca_cnt), .tmr_en(tmr_en), .skip_p0(skip_p0), .skip_p1(skip_p1),
    .skip_p2(skip_p2), .port_latch(port_latch), .periph_out(periph_out),
    .periph_oe(periph_oe), .pin_in(pin_in), .pin_sel(pin_sel), .pin_do(pin_do),
    .pin_oe(pin_oe), .periph_in(periph_in), .xbar_ovf(xbar_ovf)
  );

  // R3 request map and R12 PCA count, then sequential placement (R4..R10)
  task automatic model();
    logic [NS-1:0] req;
    logic [NP-1:0] skp;
    int ptr;
    req = '0;
    req[0] = uart_en; req[1] = uart_en;
    for (int i = 2; i <= 5; i++) req[i] = spi_en;
    req[6] = smb_en; req[7] = smb_en;
    req[8] = cmp_en; req[9] = cmp_en;
    req[10] = sysclk_en;
    for (int k = 0; k < 4; k++) req[11+k] = (int'(pca_cnt) > k);
    req[15] = tmr_en; req[16] = tmr_en;
    skp = {skip_p2, skip_p1, skip_p0};
    e_sel = '0; e_do = '0; e_in = '1; e_ovf = 1'b0;
    e_oe = xbar_en ? ~port_latch : '0;
    if (xbar_en) begin
      ptr = 0;
      for (int s = 0; s < NS; s++) begin
        if (req[s]) begin
          while (ptr < NP && skp[ptr]) ptr++;
          if (ptr < NP) begin
            e_sel[ptr*SW +: SW] = SW'(s + 1);
            e_do[ptr] = periph_out[s];
            e_oe[ptr] = periph_oe[s];
            e_in[s]   = pin_in[ptr];
            ptr++;
          end else begin
            e_ovf = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R4 R5 R6 pin_sel"}, 128'(pin_sel), 128'(e_sel));
    chk({ctx, " R8 R9 pin_do"},     128'(pin_do),  128'(e_do));
    chk({ctx, " R8 R9 pin_oe"},     128'(pin_oe),  128'(e_oe));
    chk({ctx, " R10 periph_in"},    128'(periph_in), 128'(e_in));
    chk({ctx, " R7 xbar_ovf"},      128'(xbar_ovf), 128'(e_ovf));
  endtask

  task automatic apply(input string ctx);
    model();
    @(posedge clk);
    @(negedge clk);
    check_all(ctx);
  endtask

  task automatic set_cfg(input logic en, input logic [6:0] grp, input logic [2:0] pc,
                         input logic [19:0] skp);
    xbar_en = en;
    {uart_en, spi_en, smb_en, cmp_en, sysclk_en, tmr_en} = grp[5:0];
    pca_cnt = pc;
    {skip_p2, skip_p1, skip_p0} = skp;
  endtask

  task automatic rnd_data();
    periph_out = NS'($urandom); periph_oe = NS'($urandom);
    port_latch = NP'($urandom); pin_in = NP'($urandom);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h1357));
    rst_n = 1'b0;
    set_cfg(1'b1, 7'h3F, 3'd4, 20'h0);
    rnd_data();
    repeat (3) @(negedge clk);
    // R1 reset state with active configuration on the inputs
    chk("R1 pin_sel", 128'(pin_sel), 128'(0));
    chk("R1 pin_oe", 128'(pin_oe), 128'(0));
    chk("R1 pin_do", 128'(pin_do), 128'(0));
    chk("R1 periph_in", 128'(periph_in), {111'(0), 17'h1FFFF});
    chk("R1 xbar_ovf", 128'(xbar_ovf), 128'(0));
    rst_n = 1'b1;

    // R2 crossbar off
    set_cfg(1'b0, 7'h3F, 3'd4, 20'h0);
    apply("R2 off");
    // R4 everything requested, no skips
    set_cfg(1'b1, 7'h3F, 3'd4, 20'h0);
    apply("R4 full");
    // R11 a change is not visible before the next edge
    begin
      logic [NP*SW-1:0] old_sel;
      old_sel = e_sel;
      set_cfg(1'b1, 7'h00, 3'd1, 20'h0);
      #2;
      chk("R11 hold", 128'(pin_sel), 128'(old_sel));
      apply("R11 update");
    end
    // R5 whole port 0 reserved
    set_cfg(1'b1, 7'h3F, 3'd4, 20'h000FF);
    apply("R5 port0 skipped");
    // R6 only timers enabled: land on pins 0 and 1
    set_cfg(1'b1, 7'h01, 3'd0, 20'h0);
    apply("R6 timers only");
    // R7 all pins reserved
    set_cfg(1'b1, 7'h3F, 3'd2, 20'hFFFFF);
    apply("R7 all skipped");
    // R7 partial oversubscription
    set_cfg(1'b1, 7'h3F, 3'd4, 20'h0F0F0);
    apply("R7 partial");
    // R12 pca_cnt beyond 4
    set_cfg(1'b1, 7'h00, 3'd7, 20'h0);
    apply("R12 pca 7");
    // R9 unassigned pins follow latch
    set_cfg(1'b1, 7'h00, 3'd0, 20'h00001);
    apply("R9 idle pins");

    for (int it = 0; it < 400; it++) begin
      logic [19:0] skp;
      skp = 20'($urandom) & 20'($urandom) & 20'($urandom);
      if (it % 5 == 0) skp = 20'($urandom) | 20'($urandom);
      set_cfg(($urandom % 8) != 0, 7'($urandom), 3'($urandom), skp);
      rnd_data();
      apply("R3 R10 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule